// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives one pulse-width modulated output from an 8-bit period register and a 10-bit duty value. Software writes the duty value in two pieces: an 8-bit upper part and a 2-bit lower part. Both pieces may be written at any moment. They sit in a buffer until the current period ends. At that point the buffer is copied into a shadow duty register, which the compare logic uses and which can be read back on a port.

The time base is a 10-bit count. Its upper 8 bits are the period timer and its lower 2 bits are a sub-count. The sub-count steps once per prescaled tick, so the timer advances once every four ticks. A selectable prescaler divides the input clock by 1, 4 or 16. A period ends when the timer equals the period register and the sub-count wraps. The output is set at the period start and cleared when the time base reaches the shadow duty.

A mode enable turns the generator on. While it is low, the output is forced low and all counters are held at zero.

Top module: `pwm_buffered`

## Requirements
- R1: After reset the output is low, the shadow duty reads 0, and the timer, sub-count, prescaler and period register are zero.
- R2: The duty value is {upper[7:0], lower[1:0]}: the upper write sets bits 9:2 and the lower write sets bits 1:0. The shadow duty port shows the loaded 10-bit value.
- R3: With ratio r selected by `prescale_sel` (00 gives 1, 01 gives 4, 10 or 11 gives 16), a period lasts (period + 1) × 4 × r clock cycles.
- R4: At each period boundary, three things happen on the same edge: the timer and sub-count return to zero, the buffered duty is copied into the shadow register, and the output is set.
- R5: Duty writes never change the shadow duty or the output between period boundaries. They take effect from the next boundary.
- R6: For a shadow duty D with 0 < D < 4 × (period + 1), the output stays high for exactly D × r clock cycles from each boundary, then low until the next boundary.
- R7: When the duty loaded at a boundary is zero, the output is not set and stays low for that whole period.
- R8: When D ≥ 4 × (period + 1), the output stays high for the whole period. If a duty clear and a period restart fall on the same edge, the restart (set) wins.
- R9: While `mode_en` is low, the output is low from the next edge on and the shadow duty is retained.
- R10: After `mode_en` rises, the output stays low until the first boundary. That boundary is the P-th rising edge at which `mode_en` is sampled high, where P is the period length from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Generator enable; low forces the output low and holds the counters at zero |
| prescale_sel | input | 2 | Input clock division ratio: 00 gives /1, 01 gives /4, 1x gives /16 |
| period_we | input | 1 | Period register write strobe |
| period_wdata | input | 8 | Period register write data |
| duty_hi_we | input | 1 | Duty upper-part write strobe |
| duty_hi_wdata | input | 8 | Duty bits 9:2 |
| duty_lo_we | input | 1 | Duty lower-part write strobe |
| duty_lo_wdata | input | 2 | Duty bits 1:0 |
| shadow_duty | output | 10 | Active (shadow) duty value, read-only |
| pwm_out | output | 1 | PWM output |

## Verification
Two events can land on the same edge: the period restart, which sets the output and loads the shadow, and the duty-compare clear. They coincide when the duty equals exactly 4 × (period + 1). Directed runs with that duty, and with larger duties, provoke the collision. The bench judges the result by requiring the output to stay high through every boundary with no single-cycle low pulse. Random duty writes are also timed to land on the cycle just before a boundary, and each cycle the bench compares the shadow port and the output against a model that swaps the duty only at boundaries.

// File: rtl/pwm_buffered.sv
module pwm_buffered #(
  parameter int TMR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_en,
  input  logic [1:0]         prescale_sel,
  input  logic               period_we,
  input  logic [TMR_W-1:0]   period_wdata,
  input  logic               duty_hi_we,
  input  logic [TMR_W-1:0]   duty_hi_wdata,
  input  logic               duty_lo_we,
  input  logic [1:0]         duty_lo_wdata,
  output logic [TMR_W+1:0]   shadow_duty,
  output logic               pwm_out
);
  localparam int DW    = TMR_W + 2;
  localparam int PRE_W = 4;

  logic [TMR_W-1:0] tmr_q, period_q, duty_hi_q;
  logic [1:0]       sub_q, duty_lo_q;
  logic [PRE_W-1:0] pre_q;
  logic [DW-1:0]    shadow_q;
  logic             out_q;

  logic          qtick, tmr_inc, period_evt, duty_hit;
  logic [DW-1:0] base_nxt;

  assign qtick      = (prescale_sel == 2'b00) ? 1'b1 :
                      (prescale_sel == 2'b01) ? &pre_q[1:0] : &pre_q;
  assign tmr_inc    = qtick & (&sub_q);
  assign period_evt = mode_en & tmr_inc & (tmr_q == period_q);
  assign base_nxt   = {tmr_q, sub_q} + DW'(1);
  assign duty_hit   = mode_en & qtick & (base_nxt == shadow_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q     <= '0;
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      sub_q     <= '0;
      pre_q     <= '0;
      shadow_q  <= '0;
      out_q     <= 1'b0;
    end else begin
      if (period_we)  period_q  <= period_wdata;
      if (duty_hi_we) duty_hi_q <= duty_hi_wdata;
      if (duty_lo_we) duty_lo_q <= duty_lo_wdata;
      if (!mode_en) begin
        pre_q <= '0;
        sub_q <= '0;
        tmr_q <= '0;
        out_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
        if (qtick) sub_q <= sub_q + 2'd1;
        if (period_evt) begin
          tmr_q    <= '0;
          shadow_q <= {duty_hi_q, duty_lo_q};
          out_q    <= |{duty_hi_q, duty_lo_q};
        end else begin
          if (tmr_inc)  tmr_q <= tmr_q + TMR_W'(1);
          if (duty_hit) out_q <= 1'b0;
        end
      end
    end
  end

  assign shadow_duty = shadow_q;
  assign pwm_out     = out_q;
endmodule

module pwm_buffered_chk #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_en,
  input logic             pwm_out,
  input logic [TMR_W+1:0] shadow_duty,
  input logic             period_evt,
  input logic [TMR_W-1:0] tmr,
  input logic [1:0]       subq
);
  // R9
  off_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !pwm_out);
  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_evt |=> $stable(shadow_duty));
  // R8
  restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> (pwm_out == (shadow_duty != '0)));
  // R4
  rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(period_evt));
  // R4
  base_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> (tmr == '0 && subq == 2'd0));
endmodule

bind pwm_buffered pwm_buffered_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pwm_out(pwm_out),
  .shadow_duty(shadow_duty), .period_evt(period_evt), .tmr(tmr_q), .subq(sub_q)
);

// File: tb/tb_pwm_buffered.sv
module tb_pwm_buffered;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_en;
  logic [1:0] prescale_sel;
  logic       period_we, duty_hi_we, duty_lo_we;
  logic [7:0] period_wdata, duty_hi_wdata;
  logic [1:0] duty_lo_wdata;
  logic [9:0] shadow_duty;
  logic       pwm_out;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [9:0] m_buf = '0, m_shadow = '0;

  always #10 clk = ~clk;

  pwm_buffered dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .prescale_sel(prescale_sel),
    .period_we(period_we), .period_wdata(period_wdata),
    .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
    .duty_lo_we(duty_lo_we), .duty_lo_wdata(duty_lo_wdata),
    .shadow_duty(shadow_duty), .pwm_out(pwm_out)
  );

  function automatic int ratio(input logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 16;
  endfunction

  function automatic bit exp_out(input int k, input int p, input int r, input int d);
    int m;
    if (k < p - 1) return 1'b0;
    m = (k - (p - 1)) % p;
    return (d != 0) && (m < d * r);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_cfg(input logic [1:0] sel, input logic [7:0] pr, input logic [7:0] hi,
                         input logic [1:0] lo, input int nper, input bit rnd);
    int r, p;
    bit ph, pl, e;
    logic [7:0] vh;
    logic [1:0] vl;
    string tag;
    @(negedge clk);
    mode_en = 1'b0; prescale_sel = sel;
    period_we = 1'b1; period_wdata = pr;
    duty_hi_we = 1'b1; duty_hi_wdata = hi;
    duty_lo_we = 1'b1; duty_lo_wdata = lo;
    @(negedge clk);
    period_we = 1'b0; duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    m_buf = {hi, lo};
    chk(pwm_out == 1'b0, "R9 out while off", pwm_out, 0);
    chk(shadow_duty == m_shadow, "R9 shadow kept while off", shadow_duty, m_shadow);
    mode_en = 1'b1;
    r = ratio(sel);
    p = (int'(pr) + 1) * 4 * r;
    ph = 0; pl = 0; vh = '0; vl = '0;
    for (int k = 0; k < nper * p; k++) begin
      @(negedge clk);
      if (k >= p - 1 && (k - (p - 1)) % p == 0) m_shadow = m_buf;
      if (ph) m_buf[9:2] = vh;
      if (pl) m_buf[1:0] = vl;
      ph = 0; pl = 0;
      duty_hi_we = 1'b0; duty_lo_we = 1'b0;
      e = exp_out(k, p, r, int'(m_shadow));
      if (k < p - 1)                     tag = "R10 first period low";
      else if (m_shadow == 0)            tag = "R7 zero duty";
      else if (int'(m_shadow) * r >= p)  tag = "R8 full high";
      else                               tag = "R6/R3 duty window";
      chk(pwm_out == e, tag, pwm_out, e);
      chk(shadow_duty == m_shadow, "R5 shadow only at boundary", shadow_duty, m_shadow);
      if (rnd && ($urandom % 6 == 0 || (k + 2) % p == 0)) begin
        if ($urandom % 2 == 0) begin
          vh = 8'($urandom % (int'(pr) + 2)); duty_hi_wdata = vh; duty_hi_we = 1'b1; ph = 1;
        end else begin
          vl = 2'($urandom); duty_lo_wdata = vl; duty_lo_we = 1'b1; pl = 1;
        end
      end
    end
    @(negedge clk);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    if (ph) m_buf[9:2] = vh;
    if (pl) m_buf[1:0] = vl;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; mode_en = 1'b0; prescale_sel = 2'b00;
    period_we = 1'b0; period_wdata = '0;
    duty_hi_we = 1'b0; duty_hi_wdata = '0;
    duty_lo_we = 1'b0; duty_lo_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 reset out", pwm_out, 0);
    chk(shadow_duty == 10'd0, "R1 reset shadow", shadow_duty, 0);

    run_cfg(2'b00, 8'd3, 8'd1, 2'd1, 3, 0);
    chk(shadow_duty == 10'd5, "R2 duty concatenation", shadow_duty, 5);
    run_cfg(2'b01, 8'd2, 8'd0, 2'd0, 3, 0);
    run_cfg(2'b00, 8'd2, 8'd3, 2'd0, 4, 0);
    run_cfg(2'b10, 8'd1, 8'd0, 2'd3, 3, 0);
    run_cfg(2'b11, 8'd0, 8'd0, 2'd2, 3, 0);
    run_cfg(2'b00, 8'd1, 8'd255, 2'd3, 3, 0);
    chk(shadow_duty == 10'd1023, "R2 duty concatenation max", shadow_duty, 1023);
    run_cfg(2'b01, 8'd0, 8'd0, 2'd1, 3, 0);
    run_cfg(2'b00, 8'd1, 8'd2, 2'd0, 2, 0);
    chk(pwm_out == 1'b1, "R8 high before disable", pwm_out, 1);
    mode_en = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R9 disable forces low", pwm_out, 0);
    chk(shadow_duty == 10'd8, "R9 shadow retained", shadow_duty, 8);

    for (int i = 0; i < 20; i++) begin
      logic [1:0] s;
      logic [7:0] pr;
      s  = 2'($urandom);
      pr = 8'($urandom % 6);
      run_cfg(s, pr, 8'($urandom % (int'(pr) + 2)), 2'($urandom), 3, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule